// File: doc/BRIEF.md
# Banked Program ROM Address Mapper

This block sits between a CPU's 24-bit byte address bus and two program ROMs, called P1 and P2. It decodes two 1 MiB windows: a low window at 0x000000–0x0FFFFF and a high window at 0x200000–0x2FFFFF. For each read it produces a chip select for one of the two ROMs and a ROM-local byte address. It also holds a two-bit bank register whose bits drive P2's A19 and A20 address lines. This lets a P2 of up to 32 Mbit be seen through the single 1 MiB high window.

A static size input tells the mapper how large P1 is. With a 4 or 8 Mbit P1, P1 sits in the low window and the banked P2 sits in the high window. With a 16 Mbit P1 there is no P2. P1's first half then answers in the high window and its second half in the low window. The bank register is written by the CPU through a write to any odd address in the high window. The ROM arrays, wait-state generation and all other cartridge regions lie outside the block.

Top module: `prom_bank_mapper`

## Requirements
- R1: While rst_n is low, the bank output p2_bank is 0, and it is 0 immediately after reset is released.
- R2: With p1_size 2'b00 (4 Mbit) or 2'b01 (8 Mbit), a read (cpu_rd high) in 0x000000–0x0FFFFF asserts p1_cs only. For the 8 Mbit size, rom_addr = {1'b0, cpu_addr[19:0]}.
- R3: With p1_size 2'b00 or 2'b01, a read in 0x200000–0x2FFFFF asserts p2_cs only, with rom_addr = {1'b0, cpu_addr[19:0]} and no masking by the P1 size.
- R4: With p1_size 2'b00 (4 Mbit), a P1 read forces rom_addr[19] to 0, so the 512 KiB device repeats twice in the low window.
- R5: With p1_size 2'b10 or 2'b11 (16 Mbit), p2_cs never asserts. A read in the high window asserts p1_cs with rom_addr = {1'b0, cpu_addr[19:0]}. A read in the low window asserts p1_cs with rom_addr = {1'b1, cpu_addr[19:0]}.
- R6: In the 4 and 8 Mbit sizes, a write (cpu_wr high) to an odd address in the high window loads p2_bank with cpu_data[1:0] on that clock edge. p2_bank[0] drives P2 A19 and p2_bank[1] drives P2 A20.
- R7: p2_bank keeps its value on writes to even addresses, on writes outside the high window, and on any write in the 16 Mbit sizes.
- R8: p1_cs and p2_cs are both low unless cpu_rd is high and the address lies in one of the two windows. In particular, both are low for reads at 0x100000–0x1FFFFF or at 0x300000 and above, and for writes.
- R9: A read in the high window in the cycle right after a bank write already addresses P2 through the new bank value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | CPU byte address |
| cpu_data | input | 16 | CPU write data bus |
| cpu_wr | input | 1 | Write strobe, sampled on the rising edge |
| cpu_rd | input | 1 | Read strobe |
| p1_size | input | 2 | P1 size: 00 = 4 Mbit, 01 = 8 Mbit, 1x = 16 Mbit |
| p1_cs | output | 1 | P1 chip select, active high |
| p2_cs | output | 1 | P2 chip select, active high |
| rom_addr | output | 21 | ROM-local byte address |
| p2_bank | output | 2 | Bank bits driving P2 A19 (bit 0) and A20 (bit 1) |

## Verification
The hardest case to reach from the ports is a bank write that must be ignored because of its exact conditions. Three writes isolate the three conditions that must all hold for a load: one to an odd address outside the window, one to an even address inside it, and one in the 16 Mbit size. The bench first sets a known nonzero bank and only then sends these writes. It then brings the bank back out through a later high-window read, or directly at p2_bank, so a lost or spurious load shows up as the wrong ROM word. Every read is checked against a behavioural ROM model in each size mode, both before and after the bank changes.

// File: rtl/prom_map_pkg.sv
package prom_map_pkg;
   typedef enum logic [1:0] {
      SZ_4M   = 2'b00,
      SZ_8M   = 2'b01,
      SZ_16M  = 2'b10,
      SZ_16MX = 2'b11
   } p1_size_e;

   // A 16 Mbit P1 fills both windows with its halves swapped.
   function automatic logic is_crossed(input p1_size_e sz);
      return sz[1];
   endfunction
endpackage

// File: rtl/prom_win_decode.sv
module prom_win_decode #(
   parameter int ADDR_W = 24,
   parameter int WIN_W  = 20,
   parameter int LO_IDX = 0,
   parameter int HI_IDX = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              lo_hit,
   output logic              hi_hit,
   output logic [WIN_W-1:0]  win_addr
);
   localparam int IDX_W = ADDR_W - WIN_W;

   logic [IDX_W-1:0] idx;

   assign idx      = addr[ADDR_W-1:WIN_W];
   assign win_addr = addr[WIN_W-1:0];
   assign lo_hit   = (idx == IDX_W'(LO_IDX));
   assign hi_hit   = (idx == IDX_W'(HI_IDX));
endmodule

// File: rtl/prom_bank_reg.sv
module prom_bank_reg #(
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BANK_W-1:0] din,
   output logic [BANK_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end
endmodule

// File: rtl/prom_addr_form.sv
module prom_addr_form
   import prom_map_pkg::*;
#(
   parameter int WIN_W = 20
) (
   input  logic [WIN_W-1:0] win_addr,
   input  p1_size_e         size,
   input  logic             lo_hit,
   input  logic             hi_hit,
   input  logic             rd_req,
   output logic             p1_cs,
   output logic             p2_cs,
   output logic [WIN_W:0]   loc_addr
);
   logic             crossed;
   logic [WIN_W-1:0] p1_mask;

   assign crossed = is_crossed(size);

   // The top window bit is dropped for the smallest P1, which then repeats.
   generate
      for (genvar b = 0; b < WIN_W; b++) begin : g_mask
         if (b == WIN_W - 1) begin : g_top
            assign p1_mask[b] = (size != SZ_4M);
         end else begin : g_low
            assign p1_mask[b] = 1'b1;
         end
      end
   endgenerate

   always_comb begin
      p1_cs    = 1'b0;
      p2_cs    = 1'b0;
      loc_addr = {1'b0, win_addr};
      if (rd_req) begin
         if (crossed) begin
            p1_cs    = lo_hit | hi_hit;
            loc_addr = {lo_hit, win_addr};
         end else if (lo_hit) begin
            p1_cs    = 1'b1;
            loc_addr = {1'b0, win_addr & p1_mask};
         end else if (hi_hit) begin
            p2_cs    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/prom_bank_mapper.sv
module prom_bank_mapper
   import prom_map_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int WIN_W  = 20,
   parameter int BANK_W = 2,
   parameter int LO_IDX = 0,
   parameter int HI_IDX = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [1:0]        p1_size,
   output logic              p1_cs,
   output logic              p2_cs,
   output logic [WIN_W:0]    rom_addr,
   output logic [BANK_W-1:0] p2_bank
);
   localparam int IDX_W = ADDR_W - WIN_W;

   generate
      if (IDX_W < 2) begin : g_bad_width
         $error("ADDR_W must exceed WIN_W by at least two bits");
      end
      if (BANK_W > DATA_W) begin : g_bad_bank
         $error("BANK_W cannot exceed DATA_W");
      end
      if (LO_IDX == HI_IDX) begin : g_bad_idx
         $error("LO_IDX and HI_IDX must differ");
      end
      if (HI_IDX >= (1 << IDX_W) || LO_IDX >= (1 << IDX_W)) begin : g_bad_range
         $error("window index out of range");
      end
   endgenerate

   p1_size_e         size;
   logic             lo_hit;
   logic             hi_hit;
   logic [WIN_W-1:0] win_addr;
   logic             bank_load;
   logic             unused_data;

   assign size        = p1_size_e'(p1_size);
   assign unused_data = ^cpu_data[DATA_W-1:BANK_W];

   prom_win_decode #(
      .ADDR_W(ADDR_W), .WIN_W(WIN_W), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)
   ) u_dec (
      .addr(cpu_addr), .lo_hit(lo_hit), .hi_hit(hi_hit), .win_addr(win_addr)
   );

   assign bank_load = cpu_wr & hi_hit & cpu_addr[0] & ~is_crossed(size);

   prom_bank_reg #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(bank_load),
      .din(cpu_data[BANK_W-1:0]), .q(p2_bank)
   );

   prom_addr_form #(.WIN_W(WIN_W)) u_form (
      .win_addr(win_addr), .size(size), .lo_hit(lo_hit), .hi_hit(hi_hit),
      .rd_req(cpu_rd), .p1_cs(p1_cs), .p2_cs(p2_cs), .loc_addr(rom_addr)
   );
endmodule

// File: rtl/prom_bank_mapper_chk.sv
module prom_bank_mapper_chk #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int WIN_W  = 20,
   parameter int BANK_W = 2,
   parameter int LO_IDX = 0,
   parameter int HI_IDX = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_data,
   input logic              cpu_wr,
   input logic              cpu_rd,
   input logic [1:0]        p1_size,
   input logic              p1_cs,
   input logic              p2_cs,
   input logic [WIN_W:0]    rom_addr,
   input logic [BANK_W-1:0] p2_bank
);
   localparam int IDX_W = ADDR_W - WIN_W;

   logic in_lo, in_hi, wr_odd_hi;
   assign in_lo     = cpu_addr[ADDR_W-1:WIN_W] == IDX_W'(LO_IDX);
   assign in_hi     = cpu_addr[ADDR_W-1:WIN_W] == IDX_W'(HI_IDX);
   assign wr_odd_hi = cpu_wr && in_hi && cpu_addr[0];

   AST_BANK_RESET:   assert property (@(posedge clk) !rst_n |=> p2_bank == '0); // R1
   AST_CS_EXCL:      assert property (@(posedge clk) disable iff (!rst_n) !(p1_cs && p2_cs)); // R8
   AST_NO_CS_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) (!cpu_rd || (!in_lo && !in_hi)) |-> (!p1_cs && !p2_cs)); // R8
   AST_CROSS_NO_P2:  assert property (@(posedge clk) disable iff (!rst_n) p1_size[1] |-> !p2_cs); // R5
   AST_CROSS_LO_TOP: assert property (@(posedge clk) disable iff (!rst_n) (p1_size[1] && cpu_rd && in_lo) |-> (p1_cs && rom_addr[WIN_W])); // R5
   AST_BANK_LOAD:    assert property (@(posedge clk) disable iff (!rst_n) (wr_odd_hi && !p1_size[1]) |=> p2_bank == $past(cpu_data[BANK_W-1:0])); // R6
   AST_BANK_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !(wr_odd_hi && !p1_size[1]) |=> $stable(p2_bank)); // R7
endmodule

bind prom_bank_mapper prom_bank_mapper_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W),
   .BANK_W(BANK_W), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)
) u_chk (.*);

// File: tb/prom_bank_mapper_bench.sv
module prom_bank_mapper_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic [15:0] cpu_data = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [1:0]  p1_size = 2'b01;
   logic        p1_cs, p2_cs;
   logic [20:0] rom_addr;
   logic [1:0]  p2_bank;

   always #4 clk = ~clk;

   prom_bank_mapper u_prom_bank_mapper (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .p1_size(p1_size),
      .p1_cs(p1_cs), .p2_cs(p2_cs), .rom_addr(rom_addr), .p2_bank(p2_bank)
   );

   typedef struct {
      string       tag;
      logic        p1;
      logic        p2;
      logic [20:0] addr;
      logic [1:0]  bank;
      logic [15:0] data;
   } exp_t;

   exp_t        q[$];
   int          n_chk = 0;
   int          n_fail = 0;
   logic [1:0]  exp_bank = 2'b00;
   bit          done = 0;

   // Behavioural ROM contents: word depends on device and physical location.
   function automatic logic [15:0] rom_word(input bit dev, input logic [22:0] loc);
      logic [31:0] h;
      h = {9'd0, loc} * 32'd40503 ^ {16'd0, 9'd0, loc[22:16]};
      return h[15:0] ^ (dev ? 16'hA5C3 : 16'h0000);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic do_read(input logic [23:0] a, input string tag);
      exp_t e;
      logic lo, hi;
      @(negedge clk);
      cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
      lo = (a[23:20] == 4'h0);
      hi = (a[23:20] == 4'h2);
      e.tag = tag; e.p1 = 0; e.p2 = 0; e.addr = '0; e.bank = exp_bank; e.data = '0;
      if (p1_size[1]) begin
         if (lo) begin e.p1 = 1; e.addr = {1'b1, a[19:0]}; end
         if (hi) begin e.p1 = 1; e.addr = {1'b0, a[19:0]}; end
      end else if (lo) begin
         e.p1 = 1;
         e.addr = (p1_size == 2'b00) ? {2'b00, a[18:0]} : {1'b0, a[19:0]};
      end else if (hi) begin
         e.p2 = 1; e.addr = {1'b0, a[19:0]};
      end
      if (e.p1) e.data = rom_word(1'b0, {2'b00, e.addr});
      if (e.p2) e.data = rom_word(1'b1, {1'b0, exp_bank, a[19:0]});
      q.push_back(e);
   endtask

   task automatic do_write(input logic [23:0] a, input logic [15:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      cpu_addr = a; cpu_data = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
      e.tag = tag; e.p1 = 0; e.p2 = 0; e.addr = '0; e.bank = exp_bank; e.data = '0;
      q.push_back(e);
      if (a[23:20] == 4'h2 && a[0] && !p1_size[1]) exp_bank = d[1:0];
   endtask

   task automatic set_size(input logic [1:0] s);
      @(negedge clk);
      cpu_wr = 1'b0; cpu_rd = 1'b0; p1_size = s;
   endtask

   // Monitor: samples mid-cycle, well before the next rising edge.
   initial begin
      forever begin
         exp_t e;
         logic [15:0] got;
         @(negedge clk);
         #3;
         if (q.size() > 0) begin
            e = q.pop_front();
            got = p1_cs ? rom_word(1'b0, {2'b00, rom_addr})
                : p2_cs ? rom_word(1'b1, {1'b0, p2_bank, rom_addr[19:0]}) : 16'h0000;
            check(e.tag, {31'd0, p1_cs}, {31'd0, e.p1}, "p1_cs");
            check(e.tag, {31'd0, p2_cs}, {31'd0, e.p2}, "p2_cs");
            check(e.tag, {30'd0, p2_bank}, {30'd0, e.bank}, "p2_bank");
            if (e.p1 || e.p2) begin
               check(e.tag, {11'd0, rom_addr}, {11'd0, e.addr}, "rom_addr");
               check(e.tag, {16'd0, got}, {16'd0, e.data}, "rom data");
            end
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", {30'd0, p2_bank}, 32'd0, "bank in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {30'd0, p2_bank}, 32'd0, "bank after reset");

      // 8 Mbit P1
      set_size(2'b01);
      do_read(24'h000000, "R2");
      do_read(24'h0ABCDE, "R2");
      do_read(24'h0FFFFF, "R2");
      do_read(24'h100000, "R8");
      do_read(24'h300000, "R8");
      do_read(24'hFFFFFE, "R8");
      do_read(24'h212345, "R3");
      do_write(24'h200001, 16'h0002, "R6");
      do_read(24'h212345, "R9");
      do_write(24'h200002, 16'h0003, "R7");
      do_read(24'h212345, "R7");
      do_write(24'h000001, 16'h0001, "R7");
      do_write(24'h1FFFFF, 16'h0001, "R7");
      do_read(24'h2FFFFE, "R7");
      do_write(24'h2FFFFF, 16'hFFFD, "R6");
      do_read(24'h2FFFFE, "R9");

      // 4 Mbit P1
      set_size(2'b00);
      do_read(24'h0C1234, "R4");
      do_read(24'h041234, "R4");
      do_read(24'h2C0000, "R3");
      do_write(24'h200003, 16'h0003, "R6");
      do_read(24'h2C0000, "R9");

      // 16 Mbit P1, both codes
      set_size(2'b10);
      do_read(24'h200010, "R5");
      do_read(24'h000010, "R5");
      do_write(24'h200001, 16'h0000, "R7");
      do_read(24'h2FFFFF, "R5");
      do_read(24'h180000, "R8");
      set_size(2'b11);
      do_read(24'h0F0F0E, "R5");
      do_read(24'h20A0A0, "R5");
      set_size(2'b01);
      do_read(24'h20A0A0, "R7");

      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", {30'd0, p2_bank}, 32'd0, "bank after reset pulse");
      rst_n = 1'b1;
      exp_bank = 2'b00;
      do_read(24'h20A0A0, "R1");
      repeat (3) @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule